// File: doc/BRIEF.md
# UART Register Front End with 8-Byte Register Slots

This block is the memory-mapped register face of a byte-oriented serial port. A processor reaches it through a plain 32-bit read/write port that also carries single-byte accesses. The block decodes a 256-byte window. Every logical register takes an 8-byte slot. Only the low word of a slot carries data, and the upper word always reads as zero. Software sees each register as a 64-bit register whose top half is unused.

Writing the data slot hands one byte to the bit-level transmitter. Reading the data slot takes the oldest byte out of a receive FIFO, which the bit-level receiver fills. The transmitter and receiver sit outside this block and connect through byte-wide valid/ready pairs. Status slots report whether the transmitter is full and whether the FIFO is empty. A pair of event registers, pending and enable, drives one level interrupt. The receive event stays pending for as long as unread bytes remain in the FIFO. The serial line runs at a fixed 8 data bits, no parity, 1 stop bit and 115200 baud, and no register changes this.

Top module: `uart_csr64`

## Requirements
- R1: Slot indices are taken from address bits [7:3]. Data is slot 0 (0x00), tx-full is slot 1 (0x08), rx-empty is slot 2 (0x10), event status is slot 3 (0x18), event pending is slot 4 (0x20) and event enable is slot 5 (0x28). A word access with address bit 2 set (the +4 upper word) reads 0 and its writes change nothing.
- R2: A write to the data slot while `tx_ready` is high raises `tx_valid` in that same cycle, with `tx_data` equal to write data bits [7:0]. A write to the data slot while `tx_ready` is low is dropped, and `tx_valid` stays low.
- R3: A read of the data slot returns the oldest FIFO byte in bits [7:0] and removes it, so bytes come out in arrival order. With the FIFO empty the read returns 0x00 and the FIFO is unchanged.
- R4: Bit 0 of rx-empty reads 1 exactly when the FIFO holds no byte. Bit 0 of tx-full reads 1 when `tx_ready` was low at the previous clock edge.
- R5: Event status is read-only. Bit 0 is the complement of the tx-full bit, and bit 1 is 1 when the FIFO holds at least one byte.
- R6: In the pending and enable registers, bit 0 is the transmit event and bit 1 is the receive event. Transmit pending sets when tx-full falls from 1 to 0. Writing a 1 to a pending bit clears it, and writing a 0 leaves it as it is.
- R7: Receive pending is forced to 1 on every cycle that the FIFO is non-empty, so a clear only holds once the FIFO has drained. After draining, the bit stays 1 until it is cleared.
- R8: `irq` is high exactly when some event has both its enable bit and its pending bit set.
- R9: A byte access whose address is not a multiple of 8 reads 0 and has no effect, and a data-slot byte read there does not pop the FIFO. A byte access at a multiple of 8 acts on the low byte of that slot's register.
- R10: The FIFO holds DEPTH bytes. When it is full, `rx_ready` is low, an offered byte is not taken, and the stored bytes are kept.
- R11: After reset the FIFO is empty, all enable and pending bits are 0, and `irq` is low.
- R12: `bus_rvalid` is high in the cycle after a read request and carries that read's data on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = single-byte access, 0 = 32-bit word access |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_wdata | input | 32 | Write data (byte accesses use bits [7:0]) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_data | output | 8 | Byte for the transmitter |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_ready | output | 1 | FIFO can take a byte |
| rx_data | input | 8 | Byte from the receiver |
| irq | output | 1 | Level interrupt |

## Verification
The FIFO is exercised with three patterns: a short burst drained in order, a fill past capacity, and reads while it is empty. Together these separate correct ordering from wrap, overflow and empty-pop faults. The interrupt path is exercised with receive enable on and off. A clear is written while bytes remain, then again after the FIFO drains, which shows whether the receive event is forced back and whether it is latched. Word accesses to the upper words and byte accesses at offsets other than multiples of 8 are mixed with accesses at the aligned low byte. A decode that ignores bit 2 or the low address bits would then hit a live register and show up in the results. A transmitter stall followed by its release checks that writes are dropped while it is full and that the transmit event sets on release.

// File: rtl/uart_csr64_pkg.sv
package uart_csr64_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int NSLOT  = 6;
  localparam int SLOT_W = ADDR_W - 3;
  localparam int NEV    = 2;

  typedef enum logic [SLOT_W-1:0] {
    SL_DATA   = 5'd0,
    SL_TXFULL = 5'd1,
    SL_RXEMP  = 5'd2,
    SL_STAT   = 5'd3,
    SL_PEND   = 5'd4,
    SL_EN     = 5'd5
  } slot_e;

  localparam int EV_TX = 0;
  localparam int EV_RX = 1;
endpackage

// File: rtl/ucsr_decode.sv
module ucsr_decode
  import uart_csr64_pkg::*;
(
  input  logic              req,
  input  logic              byte_acc,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  sel
);
  logic lane_ok;
  // Byte accesses need all three low bits clear; word accesses only bit 2.
  assign lane_ok = byte_acc ? (addr[2:0] == 3'b000) : (addr[2] == 1'b0);

  for (genvar s = 0; s < NSLOT; s++) begin : g_sel
    assign sel[s] = req && lane_ok && (addr[ADDR_W-1:3] == SLOT_W'(s));
  end
endmodule

// File: rtl/ucsr_rx_fifo.sv
module ucsr_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  output logic [W-1:0]             rd_data,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                     push,
  output logic                     pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ucsr_events.sv
module ucsr_events
  import uart_csr64_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_pend,
  input  logic           wr_en,
  input  logic [NEV-1:0] wbits,
  input  logic           tx_ready,
  input  logic           rx_nonempty,
  output logic           tx_full,
  output logic [NEV-1:0] pend,
  output logic [NEV-1:0] en,
  output logic           irq
);
  logic [NEV-1:0] raise, clr, pend_d, en_d;

  assign raise[EV_TX] = tx_full && tx_ready;
  assign raise[EV_RX] = rx_nonempty;
  assign clr          = wr_pend ? wbits : '0;

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    assign pend_d[e] = raise[e] || (pend[e] && !clr[e]);
  end
  assign en_d = wr_en ? wbits : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      pend    <= '0;
      en      <= '0;
      irq     <= 1'b0;
    end else begin
      tx_full <= !tx_ready;
      pend    <= pend_d;
      en      <= en_d;
      irq     <= |(pend_d & en_d);
    end
  end
endmodule

// File: rtl/uart_csr64.sv
module uart_csr64
  import uart_csr64_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [NSLOT-1:0]  sel, wr_sel, rd_sel;
  logic [BYTE_W-1:0] fifo_q;
  logic              fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic [CW-1:0]     rx_count;
  logic              tx_full_q;
  logic [NEV-1:0]    pend, en;
  logic [BUS_W-1:0]  rdata_q;
  logic              sel_data_q, data_ok_q;

  ucsr_decode u_dec (
    .req      (bus_req),
    .byte_acc (bus_byte),
    .addr     (bus_addr),
    .sel      (sel)
  );

  assign wr_sel = bus_we ? sel : '0;
  assign rd_sel = bus_we ? '0  : sel;

  assign tx_valid = wr_sel[SL_DATA] && tx_ready;
  assign tx_data  = bus_wdata[BYTE_W-1:0];

  ucsr_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rx_valid),
    .wr_data (rx_data),
    .rd_en   (rd_sel[SL_DATA]),
    .rd_data (fifo_q),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .count   (rx_count),
    .push    (fifo_push),
    .pop     (fifo_pop)
  );
  assign rx_ready = !fifo_full;

  ucsr_events u_ev (
    .clk         (clk),
    .rst         (rst),
    .wr_pend     (wr_sel[SL_PEND]),
    .wr_en       (wr_sel[SL_EN]),
    .wbits       (bus_wdata[NEV-1:0]),
    .tx_ready    (tx_ready),
    .rx_nonempty (!fifo_empty),
    .tx_full     (tx_full_q),
    .pend        (pend),
    .en          (en),
    .irq         (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      sel_data_q <= 1'b0;
      data_ok_q  <= 1'b0;
      rdata_q    <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      sel_data_q <= rd_sel[SL_DATA];
      data_ok_q  <= !fifo_empty;
      rdata_q    <= '0;
      if (rd_sel[SL_TXFULL]) rdata_q <= BUS_W'(tx_full_q);
      if (rd_sel[SL_RXEMP])  rdata_q <= BUS_W'(fifo_empty);
      if (rd_sel[SL_STAT])   rdata_q <= BUS_W'({!fifo_empty, !tx_full_q});
      if (rd_sel[SL_PEND])   rdata_q <= BUS_W'(pend);
      if (rd_sel[SL_EN])     rdata_q <= BUS_W'(en);
    end
  end

  assign bus_rdata = sel_data_q ? (data_ok_q ? BUS_W'(fifo_q) : '0) : rdata_q;
endmodule

// File: rtl/uart_csr64_chk.sv
module uart_csr64_chk
  import uart_csr64_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       fifo_push,
  input logic                       fifo_pop,
  input logic                       tx_ready,
  input logic                       tx_full_q,
  input logic [NEV-1:0]             pend,
  input logic [NEV-1:0]             en,
  input logic                       irq
);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    rx_count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r3_pop_drops_one: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && !fifo_push) |=> (rx_count == $past(rx_count) - 1'b1));

  a_r7_rx_pend_forced: assert property (@(posedge clk) disable iff (rst)
    (rx_count != '0) |=> pend[EV_RX]);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (en[EV_RX] && pend[EV_RX]) |-> irq);

  a_r4_txfull_tracks: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |=> tx_full_q);

  a_r6_tx_pend_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_full_q) |-> pend[EV_TX]);
endmodule

bind uart_csr64 uart_csr64_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_count  (rx_count),
  .fifo_push (fifo_push),
  .fifo_pop  (fifo_pop),
  .tx_ready  (tx_ready),
  .tx_full_q (tx_full_q),
  .pend      (pend),
  .en        (en),
  .irq       (irq)
);

// File: tb/sim_uart_csr64.sv
module sim_uart_csr64;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tx_valid, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq;

  int checks = 0, errors = 0;
  logic        last_tx_valid;
  logic [7:0]  last_tx_data;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_csr64 #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_byte = b; bus_addr = a; bus_wdata = d;
    #1;
    last_tx_valid = tx_valid;
    last_tx_data  = tx_data;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_byte = b; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_rx(input logic [7:0] v);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = v;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 irq after reset", irq, 0);
    bus_read(8'h10, 0, rd); check("R11 rx-empty after reset", rd, 1);
    bus_read(8'h20, 0, rd); check("R11 pending after reset", rd, 0);
    check("R12 rvalid after read", bus_rvalid, 1);
    bus_read(8'h28, 0, rd); check("R11 enable after reset", rd, 0);
    bus_read(8'h18, 0, rd); check("R5 status idle", rd, 1);
    bus_read(8'h08, 0, rd); check("R4 tx-full idle", rd, 0);
  endtask

  task automatic t_tx();
    bus_write(8'h00, 32'h1A5, 0);
    check("R2 tx_valid on write", last_tx_valid, 1);
    check("R2 tx_data low byte", last_tx_data, 8'hA5);
    @(negedge clk); tx_ready = 1'b0;
    idle(2);
    bus_read(8'h08, 0, rd); check("R4 tx-full while stalled", rd, 1);
    bus_read(8'h18, 0, rd); check("R5 status tx full", rd, 0);
    bus_write(8'h00, 32'h5A, 0);
    check("R2 write dropped when full", last_tx_valid, 0);
    @(negedge clk); tx_ready = 1'b1;
    idle(2);
    bus_read(8'h20, 0, rd); check("R6 tx pending on release", rd, 1);
    bus_write(8'h20, 32'h0, 0);
    bus_read(8'h20, 0, rd); check("R6 write 0 keeps pending", rd, 1);
    bus_write(8'h20, 32'h1, 0);
    bus_read(8'h20, 0, rd); check("R6 w1c clears tx pending", rd, 0);
  endtask

  task automatic t_rx_order();
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    idle(2);
    bus_read(8'h10, 0, rd); check("R4 rx-empty with data", rd, 0);
    bus_read(8'h18, 0, rd); check("R5 status rx data", rd, 3);
    bus_read(8'h00, 0, rd); check("R3 first byte", rd, 32'h11);
    bus_read(8'h00, 0, rd); check("R3 second byte", rd, 32'h22);
    bus_read(8'h00, 0, rd); check("R3 third byte", rd, 32'h33);
    bus_read(8'h00, 0, rd); check("R3 empty read zero", rd, 0);
    bus_read(8'h10, 0, rd); check("R3 empty read no change", rd, 1);
    bus_write(8'h20, 32'h3, 0);
    bus_read(8'h20, 0, rd); check("R7 drained clear holds", rd, 0);
  endtask

  task automatic t_rx_pend();
    bus_write(8'h28, 32'h2, 0);
    push_rx(8'h44);
    idle(2);
    check("R8 irq with rx enabled", irq, 1);
    bus_write(8'h20, 32'h2, 0);
    idle(1);
    bus_read(8'h20, 0, rd); check("R7 pending forced while data", rd, 2);
    check("R8 irq stays while data", irq, 1);
    bus_read(8'h00, 0, rd); check("R3 pend byte", rd, 32'h44);
    idle(1);
    bus_read(8'h20, 0, rd); check("R7 pending latched after drain", rd, 2);
    bus_write(8'h20, 32'h2, 0);
    idle(1);
    bus_read(8'h20, 0, rd); check("R7 clear after drain", rd, 0);
    check("R8 irq low after clear", irq, 0);
    bus_write(8'h28, 32'h0, 0);
    push_rx(8'h55);
    idle(2);
    check("R8 irq low when disabled", irq, 0);
  endtask

  task automatic t_upper();
    bus_write(8'h2C, 32'hFF, 0);
    bus_read(8'h28, 0, rd); check("R1 upper write ignored", rd, 0);
    bus_read(8'h0C, 0, rd); check("R1 upper reads zero", rd, 0);
    bus_read(8'h04, 0, rd); check("R1 data upper reads zero", rd, 0);
    bus_read(8'h10, 0, rd); check("R1 data upper no pop", rd, 0);
  endtask

  task automatic t_byte();
    bus_write(8'h29, 32'h3, 1);
    bus_read(8'h28, 0, rd); check("R9 odd byte write ignored", rd, 0);
    bus_write(8'h28, 32'h2, 1);
    bus_read(8'h28, 0, rd); check("R9 aligned byte write", rd, 2);
    bus_read(8'h01, 1, rd); check("R9 odd byte read zero", rd, 0);
    bus_read(8'h10, 1, rd); check("R9 odd byte read no pop", rd, 0);
    bus_read(8'h00, 1, rd); check("R9 aligned byte read pops", rd, 32'h55);
    bus_read(8'h10, 1, rd); check("R9 aligned byte read rx-empty", rd, 1);
    bus_write(8'h28, 32'h0, 0);
    bus_write(8'h20, 32'h3, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push_rx(8'h80 + 8'(i));
    check("R10 rx_ready low when full", rx_ready, 0);
    push_rx(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(8'h00, 0, rd);
      check("R10 drained byte", rd, 32'h80 + i);
    end
    bus_read(8'h10, 0, rd); check("R10 extra byte not kept", rd, 1);
    bus_write(8'h20, 32'h3, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    t_reset();
    t_tx();
    t_rx_order();
    t_rx_pend();
    t_upper();
    t_byte();
    t_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule